// File: doc/BRIEF.md
# Byte-Enable Test Sequencer

This block exercises a memory port with a fixed three-stage test that proves byte-lane masking works. Software first loads a base word address, a data word, a per-byte mask and two control bits, then pulses `start`. The block writes the data under the mask to three consecutive words. If inversion is enabled, it writes the complementary data under the complementary mask to the same words, so every byte lane is written exactly once. Last, it reads the three words back and compares each one with the merged word `(data & M) | (~data & ~M)`, where `M` is the mask with each bit widened to a byte.

Requests use a valid/ready handshake on a single request channel. Read responses come back in order on a read-data-valid strobe. The controller is a single state machine with these states: `ST_IDLE`, `ST_WR_PLAIN` (stage one), `ST_WR_INV` (stage two), `ST_RD_ISSUE` (stage three requests), `ST_RD_WAIT` (draining the read data) and `ST_DONE` (the one-cycle completion pulse).

The transitions are:
- IDLE→WR_PLAIN on an accepted start.
- WR_PLAIN→WR_INV when the last plain write is accepted and inversion is on; WR_PLAIN→RD_ISSUE when inversion is off.
- WR_INV→RD_ISSUE when the last inverted write is accepted.
- RD_ISSUE→RD_WAIT when the last read is accepted.
- RD_WAIT→DONE on the last read data.
- DONE→IDLE unconditionally.

The memory must return read data at least one cycle after it accepts the read.

Top module: `bet_seq`

## Requirements
- R1: Configuration writes (`cfg_wr` high) decode `cfg_addr` as follows:
  - 0x00 loads the base word address from the low `ADDR_W` bits of `cfg_wdata`.
  - 0x04 loads the data word.
  - 0x08 loads the byte mask from the low `BE_W` bits.
  - 0xAC loads the invert-enable bit from bit 0.
  - 0xB8 loads the compare-enable bit from bit 0.
  - Writes are ignored while `busy` is high.
- R2: A `start` pulse while idle makes `busy` high from the next cycle and clears `err_count` to 0. A `start` while busy or during the done cycle is ignored.
- R3: Stage one issues three writes to addresses base, base+1 and base+2, in that order, with the configured data and mask on `mem_req_be`. Bytes outside the mask stay unchanged in memory.
- R4: When invert-enable is 1, stage two issues three writes to the same three addresses with data and mask both bitwise inverted. When it is 0, stage two is skipped and only three writes occur.
- R5: Stage three issues three reads to base, base+1 and base+2, with `mem_req_be` all ones. No other word is touched by the test.
- R6: A request is taken only in a cycle where `mem_req_valid` and `mem_req_ready` are both high. While valid is high and ready is low, the address, write flag, data and mask are held stable.
- R7: With compare-enable at 1, each read response is compared with the merged expected word, and each mismatching response adds one to `err_count`.
- R8: With compare-enable at 0, read responses are not compared, `err_count` stays 0 and `pass` stays 1.
- R9: `done` is high for exactly one cycle, the cycle after the third read response. `busy` is low in that cycle. `pass` is 1 exactly when `err_count` is 0.
- R10: After reset: `busy`=0, `done`=0, `mem_req_valid`=0, `err_count`=0, `pass`=1, and all configuration fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | DATA_W | Configuration write value |
| start | input | 1 | Launch pulse |
| mem_req_valid | output | 1 | Request valid |
| mem_req_ready | input | 1 | Request accepted by memory |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | ADDR_W | Word address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_req_be | output | DATA_W/8 | Byte enables |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | DATA_W | Read data |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | No mismatches counted |
| err_count | output | clog2(NUM_OPS+1) | Mismatching read responses |

## Verification
The hardest outcome to provoke from the ports is a nonzero error count. A correct sequence with inversion enabled always reads back exactly the merged word. The bench therefore reaches mismatches in two ways:
- It disables inversion over a memory prefilled with a known pattern, so unmasked bytes keep stale data.
- Its memory model flips one bit of a chosen read response.

A repeating ready pattern stalls requests mid-stage, so hold behaviour and in-order checking are exercised together.

// File: rtl/bet_pkg.sv
package bet_pkg;

    localparam int CFG_AW = 8;

    localparam logic [CFG_AW-1:0] REG_BASE = 8'h00;
    localparam logic [CFG_AW-1:0] REG_DATA = 8'h04;
    localparam logic [CFG_AW-1:0] REG_MASK = 8'h08;
    localparam logic [CFG_AW-1:0] REG_INV  = 8'hAC;
    localparam logic [CFG_AW-1:0] REG_TEN  = 8'hB8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PLAIN,
        ST_WR_INV,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/bet_regs.sv
module bet_regs
    import bet_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              lock,
    output logic [ADDR_W-1:0] base_addr,
    output logic [DATA_W-1:0] pat_data,
    output logic [BE_W-1:0]   pat_mask,
    output logic              inv_en,
    output logic              test_en
);

    logic wr_ok;

    // Writes are only accepted while the sequencer is idle
    assign wr_ok = cfg_wr && !lock;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            pat_data  <= '0;
            pat_mask  <= '0;
            inv_en    <= 1'b0;
            test_en   <= 1'b0;
        end else if (wr_ok) begin
            unique case (cfg_addr)
                REG_BASE: base_addr <= cfg_wdata[ADDR_W-1:0];
                REG_DATA: pat_data  <= cfg_wdata;
                REG_MASK: pat_mask  <= cfg_wdata[BE_W-1:0];
                REG_INV:  inv_en    <= cfg_wdata[0];
                REG_TEN:  test_en   <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bet_ctrl.sv
module bet_ctrl
    import bet_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int BE_W    = DATA_W / 8,
    parameter int NUM_OPS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              inv_en,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DATA_W-1:0] pat_data,
    input  logic [BE_W-1:0]   pat_mask,
    input  logic              req_ready,
    input  logic              rd_valid,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic [BE_W-1:0]   req_be,
    output logic              busy,
    output logic              done,
    output logic              launch,
    output logic              rd_phase
);

    localparam int OP_W = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1;
    localparam logic [OP_W-1:0] OP_LAST = OP_W'(NUM_OPS - 1);

    seq_state_e      state, nxt;
    logic [OP_W-1:0] op_idx;
    logic [OP_W-1:0] rd_idx;
    logic            fire;
    logic            op_last;
    logic            rd_last;

    assign fire    = req_valid && req_ready;
    assign op_last = (op_idx == OP_LAST);
    assign rd_last = rd_valid && (rd_idx == OP_LAST);

    // State register and operation counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_idx <= '0;
            rd_idx <= '0;
        end else begin
            state <= nxt;
            if (launch) begin
                op_idx <= '0;
                rd_idx <= '0;
            end else begin
                if (fire) begin
                    op_idx <= op_last ? '0 : op_idx + 1'b1;
                end
                if (rd_valid && rd_phase) begin
                    rd_idx <= rd_idx + 1'b1;
                end
            end
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = ST_WR_PLAIN;
            ST_WR_PLAIN: if (fire && op_last) nxt = inv_en ? ST_WR_INV : ST_RD_ISSUE;
            ST_WR_INV:   if (fire && op_last) nxt = ST_RD_ISSUE;
            ST_RD_ISSUE: if (fire && op_last) nxt = ST_RD_WAIT;
            ST_RD_WAIT:  if (rd_last) nxt = ST_DONE;
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        req_valid = 1'b0;
        req_write = 1'b0;
        req_wdata = pat_data;
        req_be    = pat_mask;
        busy      = 1'b1;
        done      = 1'b0;
        launch    = 1'b0;
        rd_phase  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy   = 1'b0;
                launch = start;
            end
            ST_WR_PLAIN: begin
                req_valid = 1'b1;
                req_write = 1'b1;
            end
            ST_WR_INV: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_wdata = ~pat_data;
                req_be    = ~pat_mask;
            end
            ST_RD_ISSUE: begin
                req_valid = 1'b1;
                req_be    = '1;
                rd_phase  = 1'b1;
            end
            ST_RD_WAIT: begin
                req_be   = '1;
                rd_phase = 1'b1;
            end
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    assign req_addr = base_addr + ADDR_W'(op_idx);

endmodule

// File: rtl/bet_cmp.sv
module bet_cmp #(
    parameter int DATA_W  = 32,
    parameter int BE_W    = DATA_W / 8,
    parameter int NUM_OPS = 3,
    parameter int ERR_W   = $clog2(NUM_OPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] pat_data,
    input  logic [BE_W-1:0]   pat_mask,
    output logic [ERR_W-1:0]  err_count,
    output logic              pass
);

    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    logic [DATA_W-1:0] wide_mask;
    logic [DATA_W-1:0] expect_word;
    logic              mismatch;

    // Widen each mask bit across its byte lane
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign wide_mask[g*8 +: 8] = {8{pat_mask[g]}};
    end

    assign expect_word = (pat_data & wide_mask) | (~pat_data & ~wide_mask);
    assign mismatch    = (rd_data != expect_word);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_count <= '0;
        end else if (clear) begin
            err_count <= '0;
        end else if (sample && mismatch && (err_count != ERR_MAX)) begin
            err_count <= err_count + 1'b1;
        end
    end

    assign pass = (err_count == '0);

endmodule

// File: rtl/bet_seq.sv
module bet_seq
    import bet_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int NUM_OPS = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_wr,
    input  logic [7:0]                       cfg_addr,
    input  logic [DATA_W-1:0]                cfg_wdata,
    input  logic                             start,
    output logic                             mem_req_valid,
    input  logic                             mem_req_ready,
    output logic                             mem_req_write,
    output logic [ADDR_W-1:0]                mem_req_addr,
    output logic [DATA_W-1:0]                mem_req_wdata,
    output logic [DATA_W/8-1:0]              mem_req_be,
    input  logic                             mem_rd_valid,
    input  logic [DATA_W-1:0]                mem_rd_data,
    output logic                             busy,
    output logic                             done,
    output logic                             pass,
    output logic [$clog2(NUM_OPS+1)-1:0]     err_count
);

    localparam int BE_W  = DATA_W / 8;
    localparam int ERR_W = $clog2(NUM_OPS + 1);

    logic [ADDR_W-1:0] base_addr;
    logic [DATA_W-1:0] pat_data;
    logic [BE_W-1:0]   pat_mask;
    logic              inv_en;
    logic              test_en;
    logic              launch;
    logic              rd_phase;
    logic              sample;

    bet_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .lock      (busy),
        .base_addr (base_addr),
        .pat_data  (pat_data),
        .pat_mask  (pat_mask),
        .inv_en    (inv_en),
        .test_en   (test_en)
    );

    bet_ctrl #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .BE_W    (BE_W),
        .NUM_OPS (NUM_OPS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .inv_en    (inv_en),
        .base_addr (base_addr),
        .pat_data  (pat_data),
        .pat_mask  (pat_mask),
        .req_ready (mem_req_ready),
        .rd_valid  (mem_rd_valid),
        .req_valid (mem_req_valid),
        .req_write (mem_req_write),
        .req_addr  (mem_req_addr),
        .req_wdata (mem_req_wdata),
        .req_be    (mem_req_be),
        .busy      (busy),
        .done      (done),
        .launch    (launch),
        .rd_phase  (rd_phase)
    );

    assign sample = mem_rd_valid && rd_phase && test_en;

    bet_cmp #(
        .DATA_W  (DATA_W),
        .BE_W    (BE_W),
        .NUM_OPS (NUM_OPS),
        .ERR_W   (ERR_W)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (launch),
        .sample    (sample),
        .rd_data   (mem_rd_data),
        .pat_data  (pat_data),
        .pat_mask  (pat_mask),
        .err_count (err_count),
        .pass      (pass)
    );

endmodule

// File: rtl/bet_seq_chk.sv
module bet_seq_chk #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int NUM_OPS = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         start,
    input logic                         mem_req_valid,
    input logic                         mem_req_ready,
    input logic                         mem_req_write,
    input logic [ADDR_W-1:0]            mem_req_addr,
    input logic [DATA_W-1:0]            mem_req_wdata,
    input logic [DATA_W/8-1:0]          mem_req_be,
    input logic                         mem_rd_valid,
    input logic                         busy,
    input logic                         done,
    input logic [$clog2(NUM_OPS+1)-1:0] err_count
);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata) && $stable(mem_req_be));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rd_valid) && !busy);

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !done |=> busy && (err_count == '0));

    // R5
    read_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_write |-> (&mem_req_be));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid);

    // R7
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count != $past(err_count)) |-> ($past(mem_rd_valid) || $past(start)));

endmodule

bind bet_seq bet_seq_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_OPS (NUM_OPS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_req_be    (mem_req_be),
    .mem_rd_valid  (mem_rd_valid),
    .busy          (busy),
    .done          (done),
    .err_count     (err_count)
);

// File: tb/bet_seq_test.sv
`timescale 1ns/1ps
module bet_seq_test;
    import bet_pkg::*;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam logic [31:0] PREFILL = 32'hA5A5_5A5A;

    typedef struct packed {
        logic        inv;
        logic        te;
        logic        corrupt;
        logic [31:0] data;
        logic [3:0]  mask;
        logic [7:0]  rdy;
        logic [1:0]  errs;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 1'b1, 1'b0, 32'h1234_5678, 4'b0101, 8'hFF,        2'd0},
        '{1'b1, 1'b1, 1'b0, 32'hDEAD_BEEF, 4'b1111, 8'b1011_0110, 2'd0},
        '{1'b0, 1'b1, 1'b0, 32'hCAFE_F00D, 4'b0011, 8'hFF,        2'd3},
        '{1'b0, 1'b0, 1'b0, 32'hCAFE_F00D, 4'b0011, 8'b0101_0101, 2'd0},
        '{1'b1, 1'b1, 1'b1, 32'h0F0F_00FF, 4'b1010, 8'b1100_1100, 2'd1},
        '{1'b1, 1'b1, 1'b0, 32'h0000_0000, 4'b0000, 8'hFF,        2'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [7:0]        cfg_addr = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic              start = 1'b0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic              mem_req_write;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_wdata;
    logic [3:0]        mem_req_be;
    logic              mem_rd_valid = 1'b0;
    logic [DATA_W-1:0] mem_rd_data = '0;
    logic              busy, done, pass;
    logic [1:0]        err_count;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    bet_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_OPS(3)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .busy(busy), .done(done), .pass(pass), .err_count(err_count)
    );

    // Memory model: 16 words, one-cycle read latency
    logic [31:0] mem [16];
    logic [7:0]  rdy_pat = 8'hFF;
    logic        corrupt_on = 1'b0;
    logic        prefill_go = 1'b0;
    logic [2:0]  cyc = '0;
    int          rd_served = 0;

    always @(posedge clk) begin
        cyc           <= cyc + 3'd1;
        mem_req_ready <= rdy_pat[cyc];
        mem_rd_valid  <= 1'b0;
        if (prefill_go) begin
            for (int i = 0; i < 16; i++) mem[i] <= PREFILL;
            rd_served <= 0;
        end else if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                for (int b = 0; b < 4; b++)
                    if (mem_req_be[b]) mem[mem_req_addr[3:0]][b*8 +: 8] <= mem_req_wdata[b*8 +: 8];
            end else begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= mem[mem_req_addr[3:0]] ^ ((corrupt_on && rd_served == 1) ? 32'h1 : 32'h0);
                rd_served    <= rd_served + 1;
            end
        end
    end

    // Monitor: handshake counts, read order, done timing
    logic mon_clear = 1'b0;
    int   wr_hs, rd_hs, rd_ret, done_cnt, rd_addr_bad, done_bad;
    int   mon_base = 0;
    logic prev_rdv = 1'b0;

    always @(negedge clk) begin
        if (mon_clear || !rst_n) begin
            wr_hs = 0; rd_hs = 0; rd_ret = 0; done_cnt = 0;
            rd_addr_bad = 0; done_bad = 0; prev_rdv = 1'b0;
        end else begin
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) wr_hs++;
                else begin
                    if (mem_req_addr != ADDR_W'(mon_base + rd_hs) || mem_req_be != 4'hF) rd_addr_bad++;
                    rd_hs++;
                end
            end
            if (done) begin
                done_cnt++;
                if (!prev_rdv || rd_ret != 3 || busy) done_bad++;
            end
            if (mem_rd_valid) rd_ret++;
            prev_rdv = mem_rd_valid;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic [31:0] widen(input logic [3:0] m);
        logic [31:0] w;
        for (int b = 0; b < 4; b++) w[b*8 +: 8] = {8{m[b]}};
        return w;
    endfunction

    task automatic run(input vec_t v, input int base, input bit disturb);
        logic [31:0] w, ew;
        int t;
        rdy_pat = v.rdy; corrupt_on = v.corrupt; mon_base = base;
        prefill_go = 1'b1; mon_clear = 1'b1;
        @(negedge clk);
        prefill_go = 1'b0; mon_clear = 1'b0;
        cfg_write(REG_BASE, base);
        cfg_write(REG_DATA, v.data);
        cfg_write(REG_MASK, {28'h0, v.mask});
        cfg_write(REG_INV, {31'h0, v.inv});
        cfg_write(REG_TEN, {31'h0, v.te});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R2 busy after start", busy, 1);
        if (disturb) begin
            repeat (2) @(negedge clk);
            start = 1'b1; cfg_wr = 1'b1; cfg_addr = REG_DATA; cfg_wdata = 32'hFFFF_FFFF;
            @(negedge clk);
            start = 1'b0; cfg_wr = 1'b0;
        end
        t = 0;
        while (done_cnt == 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
        chk(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
        chk(done_bad == 0, "R9 done timing after third read", done_bad, 0);
        chk(busy === 1'b0, "R9 busy low at end", busy, 0);
        chk(err_count == v.errs, v.te ? "R7 error count" : "R8 no compare", err_count, v.errs);
        chk(pass === (v.errs == 0), "R9 pass flag", pass, v.errs == 0);
        chk(wr_hs == (v.inv ? 6 : 3), "R4 write count", wr_hs, v.inv ? 6 : 3);
        chk(rd_hs == 3, "R5 read count", rd_hs, 3);
        chk(rd_addr_bad == 0, "R5 read address order", rd_addr_bad, 0);
        w = widen(v.mask);
        ew = v.inv ? ((v.data & w) | (~v.data & ~w)) : ((v.data & w) | (PREFILL & ~w));
        for (int i = 0; i < 3; i++)
            chk(mem[base + i] == ew, v.inv ? "R4 memory word" : "R3 memory word", mem[base + i], ew);
        chk(mem[base + 3] == PREFILL, "R3 neighbour untouched", mem[base + 3], PREFILL);
    endtask

    initial begin
        #750us;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy === 1'b0, "R10 busy", busy, 0);
        chk(done === 1'b0, "R10 done", done, 0);
        chk(mem_req_valid === 1'b0, "R10 valid", mem_req_valid, 0);
        chk(pass === 1'b1, "R10 pass", pass, 1);
        chk(err_count === 2'd0, "R10 err_count", err_count, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) run(VECS[i], i * 2, 1'b0);

        // R1 R2: config write and start while busy are ignored
        run(VECS[0], 4, 1'b1);

        // R10: reset in mid-run
        rdy_pat = 8'hFF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R10 busy after mid-run reset", busy, 0);
        chk(mem_req_valid === 1'b0, "R10 valid after mid-run reset", mem_req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: fields return to 0 (base 0 reads start at address 0)
        run(VECS[1], 0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule